// File: doc/BRIEF.md
# DRAM Page-Mode Hit Controller

This block sequences the row strobe, column strobe and multiplexed address of a single-bank DRAM for a processor bus that allows one transaction to be pipelined behind the current one. While no transfer is in progress it registers the bus address on every clock and places its row field on the memory address pins. The row is therefore already present when a transaction starts, and the row strobe can follow two cycles after the start strobe.

When a burst is followed by a pipelined DRAM access, the rows of the two accesses are compared in the last column cycle of the final beat. If they match, the row stays open and the next access begins with a single column-gap cycle. If they differ, precharge starts in the very next cycle, so a miss costs nothing beyond a normal row cycle. A read that must first wait for an external cache castout opens its row as usual. Its column strobe is held back until the castout data has filled an internal buffer. A flag then tells a later write-back sequence that the buffer holds data.

The state machine has seven states. ST_IDLE waits for a request. ST_ROWOUT drives the row and acknowledges the address. ST_ACT holds the row strobe for the row-to-column delay. ST_COHOLD stalls for the castout. ST_COLRD is one column beat. ST_COLGAP is the one-cycle column gap between beats or before a page hit. ST_PRECH is row precharge. The transitions are:
- ST_IDLE to ST_ROWOUT on an accepted start, or on a waiting pipelined request.
- ST_ROWOUT to ST_ACT.
- ST_ACT to ST_COHOLD when a castout read finds the buffer not yet full, and otherwise to ST_COLRD.
- ST_COHOLD to ST_COLRD once the buffer is full.
- ST_COLRD to ST_COLGAP for the next beat or on a page hit, and to ST_PRECH otherwise.
- ST_COLGAP to ST_COLRD.
- ST_PRECH to ST_ACT when a pipelined request waits, and to ST_IDLE otherwise.

Top module: `dram_page_ctl`

## Requirements
- R1: Whenever the controller is idle, ma_o in each cycle equals the row field addr_i[22:11] as sampled at the previous clock edge.
- R2: A start strobe sampled at edge E with addr_i[31]=0 (DRAM) gives aack_o=1 and the row of that address on ma_o, with ras_n_o still high, in the cycle after E. ras_n_o goes low in the cycle after that.
- R3: A start strobe with addr_i[31]=1 is not for DRAM: it produces no aack_o, and ras_n_o stays high.
- R4: The row strobe is low for t_rcd_i cycles before the column strobe falls. Each beat holds cas_n_o low for t_cas_i cycles. Precharge holds ras_n_o high for t_rp_i cycles. A programmed value of 0 behaves as 1.
- R5: burst_i=0 gives 1 beat and burst_i=1 gives 4 beats. ta_o pulses in the last low cycle of each beat. During a beat, ma_o equals addr_i[10:3] plus the beat index, zero-extended to 12 bits. cas_n_o is high for one cycle between beats.
- R6: While busy, one further DRAM start strobe is accepted and acknowledged with aack_o in the next cycle. A start strobe that arrives while that pipeline slot is occupied is ignored.
- R7: Page hit: the current access is a burst, the pipelined access is DRAM, is not a castout read, and has the same row. In that case ras_n_o stays low, and the first beat of the pipelined access follows after one cas_n_o-high cycle.
- R8: Page miss: in the cycle after the final beat, ras_n_o goes high for t_rp_i cycles while ma_o shows the new row. Then come the row-to-column delay and the new beats.
- R9: When the current access is a single beat, the row is always precharged before a pipelined access, even if the rows are equal.
- R10: For a read with castout_i=1, ras_n_o falls as usual, but cas_n_o stays high until the castout buffer is full. The read then completes.
- R11: Each co_beat_i pulse writes one castout beat. The fourth beat sets co_full_o, which stays set until a co_drain_i pulse clears it in the next cycle.
- R12: During reset, ras_n_o=1, cas_n_o=1, ta_o=0, aack_o=0 and co_full_o=0.
- R13: cas_n_o is never low while ras_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_i | input | 1 | Transaction start strobe |
| addr_i | input | 32 | Processor byte address |
| burst_i | input | 1 | 1 = four-beat burst, 0 = single beat |
| castout_i | input | 1 | Read needs a cache castout first |
| co_beat_i | input | 1 | One castout beat written into the buffer |
| co_drain_i | input | 1 | Write-back has emptied the castout buffer |
| t_rp_i | input | 3 | Precharge cycles |
| t_rcd_i | input | 3 | Row-to-column cycles |
| t_cas_i | input | 3 | Column strobe width in cycles |
| aack_o | output | 1 | Address phase acknowledge |
| ta_o | output | 1 | Data beat acknowledge |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| ma_o | output | 12 | Multiplexed row/column address |
| co_full_o | output | 1 | Castout buffer holds data to drain |

## Verification
Some properties are checked by the embedded assertions on every cycle: the column strobe only under an open row, the open row held across a page hit, precharge immediately after a miss, the column strobe held off during a castout stall, the stickiness of the buffer-full flag, and a timing counter that never reaches zero. Other behaviour only the bench scenarios can show: the exact cycle in which each beat is acknowledged for different timing settings, the column sequence within a burst, the idle row tracking, the rejection of non-DRAM and surplus pipelined requests, and the latency difference between a hit and a miss.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROWOUT,
        ST_ACT,
        ST_COHOLD,
        ST_COLRD,
        ST_COLGAP,
        ST_PRECH
    } dpc_state_e;

    typedef enum logic [1:0] {
        MA_LIVE,
        MA_CUR_ROW,
        MA_NXT_ROW,
        MA_COLUMN
    } ma_sel_e;

endpackage

// File: rtl/dpc_timer.sv
module dpc_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          last_o
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= TW'(1);
        end else if (load_i) begin
            cnt_q <= (val_i == '0) ? TW'(1) : val_i;
        end else if (cnt_q > TW'(1)) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign last_o = (cnt_q == TW'(1));

    // R4: a timed state always lasts at least one cycle
    p_cnt_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);

endmodule

// File: rtl/dpc_castout_buf.sv
module dpc_castout_buf #(
    parameter int CO_BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic co_beat_i,
    input  logic drain_i,
    output logic full_o
);
    localparam int CW = $clog2(CO_BEATS + 1);

    logic [CW-1:0] cnt_q;
    logic          full_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (drain_i) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (co_beat_i && !full_q) begin
            if (cnt_q == CW'(CO_BEATS - 1)) begin
                cnt_q  <= '0;
                full_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign full_o = full_q;

    // R11: the flag survives until a drain
    p_full_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        full_q && !drain_i |=> full_q);

endmodule

// File: rtl/dpc_addr_path.sv
module dpc_addr_path
    import dpc_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  bus_row_i,
    input  logic [ROW_W-1:0]  cur_row_i,
    input  logic [ROW_W-1:0]  nxt_row_i,
    input  logic [COL_W-1:0]  cur_col_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  ma_sel_e           sel_i,
    output logic [ROW_W-1:0]  ma_o,
    output logic              row_match_o
);
    logic [ROW_W-1:0] live_row_q;
    logic [COL_W-1:0] col_sum;

    always_ff @(posedge clk) begin
        if (!rst_n) live_row_q <= '0;
        else        live_row_q <= bus_row_i;
    end

    assign col_sum     = cur_col_i + COL_W'(beat_i);
    assign row_match_o = (cur_row_i == nxt_row_i);

    always_comb begin
        unique case (sel_i)
            MA_LIVE:    ma_o = live_row_q;
            MA_CUR_ROW: ma_o = cur_row_i;
            MA_NXT_ROW: ma_o = nxt_row_i;
            MA_COLUMN:  ma_o = ROW_W'(col_sum);
            default:    ma_o = live_row_q;
        endcase
    end

endmodule

// File: rtl/dram_page_ctl.sv
module dram_page_ctl
    import dpc_pkg::*;
#(
    parameter int AW          = 32,
    parameter int ROW_LSB     = 11,
    parameter int ROW_W       = 12,
    parameter int COL_LSB     = 3,
    parameter int TW          = 3,
    parameter int BURST_BEATS = 4,
    parameter int CO_BEATS    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             burst_i,
    input  logic             castout_i,
    input  logic             co_beat_i,
    input  logic             co_drain_i,
    input  logic [TW-1:0]    t_rp_i,
    input  logic [TW-1:0]    t_rcd_i,
    input  logic [TW-1:0]    t_cas_i,
    output logic             aack_o,
    output logic             ta_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic [ROW_W-1:0] ma_o,
    output logic             co_full_o
);
    localparam int COL_W   = ROW_LSB - COL_LSB;
    localparam int BEAT_W  = $clog2(BURST_BEATS);
    localparam int ROW_MSB = ROW_LSB + ROW_W - 1;

    logic [ROW_W-1:0] in_row;
    logic [COL_W-1:0] in_col;
    logic             in_dram;
    logic             unused_addr_bits;

    assign in_row  = addr_i[ROW_MSB:ROW_LSB];
    assign in_col  = addr_i[ROW_LSB-1:COL_LSB];
    assign in_dram = !addr_i[AW-1];
    assign unused_addr_bits = ^{addr_i[AW-2:ROW_MSB+1], addr_i[COL_LSB-1:0]};

    dpc_state_e state_q, state_d;

    logic [ROW_W-1:0]  cur_row_q, nxt_row_q;
    logic [COL_W-1:0]  cur_col_q, nxt_col_q;
    logic              cur_burst_q, nxt_burst_q, cur_co_q, nxt_co_q, nxt_v_q;
    logic [BEAT_W-1:0] beat_q;
    logic              aack_q;

    logic take_idle, take_pipe, promote, t_last, last_beat, final_cas;
    logic page_hit, row_match, co_full, tmr_load;
    logic [TW-1:0] tmr_val;
    ma_sel_e ma_sel;

    assign take_idle = (state_q == ST_IDLE) && !nxt_v_q && ts_i && in_dram;
    assign take_pipe = (state_q != ST_IDLE) && !nxt_v_q && ts_i && in_dram;
    assign last_beat = beat_q == (cur_burst_q ? BEAT_W'(BURST_BEATS - 1) : '0);
    assign final_cas = (state_q == ST_COLRD) && t_last && last_beat;
    assign page_hit  = final_cas && nxt_v_q && cur_burst_q && !nxt_co_q && row_match;

    // next-state logic
    always_comb begin
        state_d = state_q;
        promote = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (nxt_v_q) begin
                    promote = 1'b1;
                    state_d = ST_ROWOUT;
                end else if (take_idle) begin
                    state_d = ST_ROWOUT;
                end
            end
            ST_ROWOUT: state_d = ST_ACT;
            ST_ACT: begin
                if (t_last) state_d = (cur_co_q && !co_full) ? ST_COHOLD : ST_COLRD;
            end
            ST_COHOLD: begin
                if (co_full) state_d = ST_COLRD;
            end
            ST_COLRD: begin
                if (t_last) begin
                    if (!last_beat) begin
                        state_d = ST_COLGAP;
                    end else if (page_hit) begin
                        promote = 1'b1;
                        state_d = ST_COLGAP;
                    end else begin
                        state_d = ST_PRECH;
                    end
                end
            end
            ST_COLGAP: state_d = ST_COLRD;
            ST_PRECH: begin
                if (t_last) begin
                    if (nxt_v_q) begin
                        promote = 1'b1;
                        state_d = ST_ACT;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transaction slots, beat index, address acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row_q <= '0; cur_col_q <= '0; cur_burst_q <= 1'b0; cur_co_q <= 1'b0;
            nxt_row_q <= '0; nxt_col_q <= '0; nxt_burst_q <= 1'b0; nxt_co_q <= 1'b0;
            nxt_v_q   <= 1'b0;
            beat_q    <= '0;
            aack_q    <= 1'b0;
        end else begin
            aack_q <= take_idle || take_pipe;
            if (take_idle) begin
                cur_row_q <= in_row; cur_col_q <= in_col;
                cur_burst_q <= burst_i; cur_co_q <= castout_i;
            end else if (promote) begin
                cur_row_q <= nxt_row_q; cur_col_q <= nxt_col_q;
                cur_burst_q <= nxt_burst_q; cur_co_q <= nxt_co_q;
            end
            if (take_pipe) begin
                nxt_v_q <= 1'b1;
                nxt_row_q <= in_row; nxt_col_q <= in_col;
                nxt_burst_q <= burst_i; nxt_co_q <= castout_i;
            end else if (promote) begin
                nxt_v_q <= 1'b0;
            end
            if (take_idle || promote)                                beat_q <= '0;
            else if (state_q == ST_COLRD && t_last && !last_beat)   beat_q <= beat_q + BEAT_W'(1);
        end
    end

    // timer reload on every state change
    assign tmr_load = (state_d != state_q);
    always_comb begin
        unique case (state_d)
            ST_ACT:   tmr_val = t_rcd_i;
            ST_COLRD: tmr_val = t_cas_i;
            ST_PRECH: tmr_val = t_rp_i;
            default:  tmr_val = TW'(1);
        endcase
    end

    // outputs
    always_comb begin
        ras_n_o = 1'b1;
        cas_n_o = 1'b1;
        ta_o    = 1'b0;
        ma_sel  = MA_LIVE;
        unique case (state_q)
            ST_IDLE:   ma_sel = MA_LIVE;
            ST_ROWOUT: ma_sel = MA_CUR_ROW;
            ST_ACT, ST_COHOLD: begin
                ma_sel  = MA_CUR_ROW;
                ras_n_o = 1'b0;
            end
            ST_COLRD: begin
                ma_sel  = MA_COLUMN;
                ras_n_o = 1'b0;
                cas_n_o = 1'b0;
                ta_o    = t_last;
            end
            ST_COLGAP: begin
                ma_sel  = MA_COLUMN;
                ras_n_o = 1'b0;
            end
            ST_PRECH:  ma_sel = nxt_v_q ? MA_NXT_ROW : MA_CUR_ROW;
            default:   ma_sel = MA_LIVE;
        endcase
    end

    assign aack_o    = aack_q;
    assign co_full_o = co_full;

    dpc_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .last_o(t_last)
    );

    dpc_castout_buf #(.CO_BEATS(CO_BEATS)) u_cobuf (
        .clk(clk), .rst_n(rst_n), .co_beat_i(co_beat_i), .drain_i(co_drain_i), .full_o(co_full)
    );

    dpc_addr_path #(.ROW_W(ROW_W), .COL_W(COL_W), .BEAT_W(BEAT_W)) u_apath (
        .clk(clk), .rst_n(rst_n), .bus_row_i(in_row), .cur_row_i(cur_row_q),
        .nxt_row_i(nxt_row_q), .cur_col_i(cur_col_q), .beat_i(beat_q),
        .sel_i(ma_sel), .ma_o(ma_o), .row_match_o(row_match)
    );

    // R13: column strobe only under an open row
    p_cas_under_ras_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n_o |-> !ras_n_o);

    // R5: a data acknowledge only during a column strobe
    p_ta_in_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ta_o |-> !cas_n_o);

    // R7: a page hit keeps the row open and inserts a column gap
    p_hit_holds_ras_r7: assert property (@(posedge clk) disable iff (!rst_n)
        page_hit |=> !ras_n_o && cas_n_o);

    // R8: a miss precharges in the next cycle
    p_miss_precharge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        final_cas && nxt_v_q && !page_hit |=> ras_n_o);

    // R10: column strobe held while castout data is outstanding
    p_castout_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACT || state_q == ST_COHOLD) && cur_co_q && !co_full |=> cas_n_o);

endmodule

// File: tb/dram_page_ctl_tb_top.sv
module dram_page_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PROBE = 32'h00AB_C000;

    logic clk, rst_n, ts_i, burst_i, castout_i, co_beat_i, co_drain_i;
    logic [31:0] addr_i;
    logic [2:0]  t_rp_i, t_rcd_i, t_cas_i;
    logic aack_o, ta_o, ras_n_o, cas_n_o, co_full_o;
    logic [11:0] ma_o;

    dram_page_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .ts_i(ts_i), .addr_i(addr_i), .burst_i(burst_i),
        .castout_i(castout_i), .co_beat_i(co_beat_i), .co_drain_i(co_drain_i),
        .t_rp_i(t_rp_i), .t_rcd_i(t_rcd_i), .t_cas_i(t_cas_i), .aack_o(aack_o),
        .ta_o(ta_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .ma_o(ma_o), .co_full_o(co_full_o)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct packed {
        logic [31:0] a;
        logic        b;
        logic [2:0]  rcd, cas, rp;
        logic [7:0]  first, beats, raslow, idle;
    } vec_t;

    localparam vec_t VECS [0:3] = '{
        '{32'h0001_2340, 1'b0, 3'd2, 3'd2, 3'd2, 8'd5, 8'd1, 8'd4,  8'd8},
        '{32'h0023_4500, 1'b1, 3'd1, 3'd1, 3'd1, 8'd3, 8'd4, 8'd8,  8'd11},
        '{32'h0045_6780, 1'b1, 3'd3, 3'd2, 3'd2, 8'd6, 8'd4, 8'd14, 8'd18},
        '{32'h0067_8900, 1'b0, 3'd0, 3'd0, 3'd0, 8'd3, 8'd1, 8'd2,  8'd5}
    };

    int          ta_k  [0:15];
    logic [11:0] ta_ma [0:15];
    int          nta;
    logic        ras_h [0:63];
    logic        cas_h [0:63];
    logic        aack_h[0:63];
    logic        cof_h [0:63];
    logic [11:0] ma_h  [0:63];

    function automatic logic [11:0] row_of(input logic [31:0] a);
        return a[22:11];
    endfunction

    function automatic logic [11:0] col_of(input logic [31:0] a, input int beat);
        logic [7:0] c;
        c = a[10:3] + 8'(beat);
        return {4'b0, c};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_t(input logic [2:0] rcd, input logic [2:0] cas, input logic [2:0] rp);
        t_rcd_i = rcd; t_cas_i = cas; t_rp_i = rp;
    endtask

    // Starts at a negedge; cycle k is sampled at the negedge after the k-th edge.
    task automatic run(input logic [31:0] a, input logic b, input logic co, input int w,
                       input int p1_k, input logic [31:0] p1_a, input logic p1_b,
                       input int p2_k, input logic [31:0] p2_a,
                       input int co_k, input int probe_k);
        nta = 0;
        ts_i = 1'b1; addr_i = a; burst_i = b; castout_i = co;
        for (int k = 1; k <= w; k++) begin
            @(negedge clk);
            ras_h[k] = ras_n_o; cas_h[k] = cas_n_o; aack_h[k] = aack_o;
            cof_h[k] = co_full_o; ma_h[k] = ma_o;
            if (ta_o && nta < 16) begin
                ta_k[nta] = k; ta_ma[nta] = ma_o; nta++;
            end
            ts_i = 1'b0; castout_i = 1'b0; co_beat_i = 1'b0;
            if (k == p1_k) begin ts_i = 1'b1; addr_i = p1_a; burst_i = p1_b; end
            if (k == p2_k) begin ts_i = 1'b1; addr_i = p2_a; burst_i = 1'b1; end
            if (co_k > 0 && k >= co_k && k < co_k + 4) co_beat_i = 1'b1;
            if (k == probe_k) addr_i = PROBE;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ts_i = 1'b0; addr_i = '0; burst_i = 1'b0; castout_i = 1'b0;
        co_beat_i = 1'b0; co_drain_i = 1'b0;
        set_t(3'd1, 3'd1, 3'd1);
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(ras_n_o && cas_n_o && !ta_o && !aack_o && !co_full_o, "R12 reset outputs",
            int'({ras_n_o, cas_n_o, ta_o, aack_o, co_full_o}), 24);
        rst_n = 1'b1;
        @(negedge clk);

        // table of transactions: latency, beats, row time, column sequence, return to idle
        for (int v = 0; v < 4; v++) begin
            int raslow;
            int w;
            w = int'(VECS[v].idle) + 1;
            set_t(VECS[v].rcd, VECS[v].cas, VECS[v].rp);
            run(VECS[v].a, VECS[v].b, 1'b0, w, 0, '0, 1'b0, 0, '0, 0, int'(VECS[v].idle) - 1);
            chk(aack_h[1] && ras_h[1] && ma_h[1] == row_of(VECS[v].a), "R2 address phase",
                int'(ma_h[1]), int'(row_of(VECS[v].a)));
            chk(!ras_h[2], "R2 row strobe two cycles after start", int'(ras_h[2]), 0);
            chk(nta == int'(VECS[v].beats), "R5 beat count", nta, int'(VECS[v].beats));
            chk(nta > 0 && ta_k[0] == int'(VECS[v].first), "R4 first beat latency",
                (nta > 0) ? ta_k[0] : -1, int'(VECS[v].first));
            raslow = 0;
            for (int k = 1; k <= w; k++) if (!ras_h[k]) raslow++;
            chk(raslow == int'(VECS[v].raslow), "R4 row strobe low time", raslow, int'(VECS[v].raslow));
            for (int j = 0; j < nta; j++)
                chk(ta_ma[j] == col_of(VECS[v].a, j), "R5 column address",
                    int'(ta_ma[j]), int'(col_of(VECS[v].a, j)));
            chk(ma_h[VECS[v].idle] == row_of(PROBE) && ras_h[VECS[v].idle], "R1 idle row tracking",
                int'(ma_h[VECS[v].idle]), int'(row_of(PROBE)));
        end

        // R1: idle address follows the bus every cycle
        addr_i = 32'h0055_5800;
        @(negedge clk);
        chk(ma_o == row_of(32'h0055_5800), "R1 idle latch", int'(ma_o), int'(row_of(32'h0055_5800)));
        addr_i = 32'h0012_3800;
        @(negedge clk);
        chk(ma_o == row_of(32'h0012_3800), "R1 idle latch second", int'(ma_o), int'(row_of(32'h0012_3800)));

        // R3: non-DRAM start ignored
        set_t(3'd1, 3'd1, 3'd1);
        run(32'h8000_1000, 1'b1, 1'b0, 6, 0, '0, 1'b0, 0, '0, 0, 0);
        begin
            int bad;
            bad = 0;
            for (int k = 1; k <= 6; k++) if (aack_h[k] || !ras_h[k]) bad++;
            chk(bad == 0 && nta == 0, "R3 non-DRAM start ignored", bad + nta, 0);
        end

        // R7 page hit, R6 pipelining with a surplus request
        run(32'h0010_0000, 1'b1, 1'b0, 22, 4, 32'h0010_0040, 1'b1, 5, 32'h0030_0000, 0, 0);
        chk(aack_h[5] && !aack_h[6], "R6 one pipelined request acknowledged",
            int'({aack_h[5], aack_h[6]}), 2);
        chk(nta == 8, "R6 surplus request ignored", nta, 8);
        chk(!ras_h[10] && cas_h[10], "R7 row kept open on hit", int'(ras_h[10]), 0);
        chk(nta > 4 && ta_k[4] == 11, "R7 hit latency", (nta > 4) ? ta_k[4] : -1, 11);
        chk(nta > 4 && ta_ma[4] == col_of(32'h0010_0040, 0), "R5 column of pipelined access",
            (nta > 4) ? int'(ta_ma[4]) : -1, int'(col_of(32'h0010_0040, 0)));
        begin
            int bad;
            bad = 0;
            for (int k = 1; k <= 22; k++) if (!cas_h[k] && ras_h[k]) bad++;
            chk(bad == 0, "R13 no column strobe without row", bad, 0);
        end

        // R8 page miss
        run(32'h0010_0000, 1'b1, 1'b0, 22, 4, 32'h0020_0000, 1'b1, 0, '0, 0, 0);
        chk(ras_h[10] && ma_h[10] == row_of(32'h0020_0000), "R8 precharge with new row",
            int'(ma_h[10]), int'(row_of(32'h0020_0000)));
        chk(!ras_h[11], "R8 row reopened after precharge", int'(ras_h[11]), 0);
        chk(nta == 8 && ta_k[4] == 12, "R8 miss latency", (nta > 4) ? ta_k[4] : -1, 12);

        // R9 single then same row: closes anyway
        run(32'h0010_0000, 1'b0, 1'b0, 10, 2, 32'h0010_0008, 1'b0, 0, '0, 0, 0);
        chk(ras_h[4], "R9 single access precharges", int'(ras_h[4]), 1);
        chk(nta == 2 && ta_k[1] == 6, "R9 second access latency", (nta > 1) ? ta_k[1] : -1, 6);

        // R10 castout stall, R11 buffer flag
        run(32'h0010_0000, 1'b0, 1'b1, 14, 0, '0, 1'b0, 0, '0, 4, 0);
        begin
            int bad;
            bad = 0;
            for (int k = 3; k <= 8; k++) if (!cas_h[k] || ras_h[k]) bad++;
            chk(bad == 0, "R10 column held, row open during castout", bad, 0);
        end
        chk(nta == 1 && ta_k[0] == 9, "R10 read completes after fill", (nta > 0) ? ta_k[0] : -1, 9);
        chk(!cof_h[7] && cof_h[8], "R11 full after fourth beat", int'({cof_h[7], cof_h[8]}), 1);
        chk(co_full_o, "R11 flag held until drain", int'(co_full_o), 1);
        co_drain_i = 1'b1;
        @(negedge clk);
        co_drain_i = 1'b0;
        chk(!co_full_o, "R11 drain clears flag", int'(co_full_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule